// File: doc/BRIEF.md
# Waveform Timer Counter

This block is a counter that runs up or down and drives a single waveform pin. One select picks how wide the counter is: 8, 16 or 32 bits. A second select picks one of four waveform modes. Two modes make a frequency output by toggling the pin. The other two make a pulse-width output by setting and clearing it. The counter moves by one step on each count tick while the block is enabled. Tick generation (prescaling) is done outside this block.

The wrap point (the top) comes from one of three sources: the period input, the all-ones value of the selected width, or compare channel 0. Which source is used depends on both the waveform mode and the width. On a compare match or on a wraparound, the pin toggles, sets or clears. The action depends on the mode, and in the pulse-width modes also on the count direction. Each enabled tick that lands on a match or a wrap produces a one-cycle pulse on the matching output.

Top module: `wavetimer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `count`, `wave`, `match_pulse` and `wrap_pulse` are all 0.
- R2: The count changes only at a clock edge where `enable` and `tick` are both 1. Counting up adds 1 and counting down (`count_down`=1) subtracts 1. The pulses are raised only in the cycle after such an edge.
- R3: `width_sel` encoding: 0 selects 16 bits, 1 selects 8 bits, 2 selects 32 bits, and 3 behaves as 16 bits. The `count` output and every comparison use only the low bits of the selected width.
- R4: In `wave_mode` 0 (frequency, period top) and 2 (pulse-width, period top), the top is `period` at 8-bit width and the all-ones value of the width at 16 and 32 bits.
- R5: In `wave_mode` 1 (frequency, compare top) and 3 (pulse-width, compare top), the top is `cmp0` masked to the width.
- R6: Counting up, a tick taken while the count is at or above the top loads 0. Counting down, a tick taken at count 0 loads the top. In both cases `wrap_pulse` is high for exactly the next cycle.
- R7: A tick taken while the masked count equals the masked `cmp0` raises `match_pulse` for the next cycle.
- R8: In `wave_mode` 0 and 1, `wave` toggles on a match tick and is left unchanged by a wrap.
- R9: In `wave_mode` 2 and 3, a wrap tick sets `wave` when counting up and clears it when counting down. A match tick clears it when counting up and sets it when counting down. If a tick is both a wrap and a match, the wrap action wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows the counter to advance |
| tick | input | 1 | Count step request |
| count_down | input | 1 | 1 = count down, 0 = count up |
| width_sel | input | 2 | Counter width select (R3) |
| wave_mode | input | 2 | Waveform mode select (R4, R5, R8, R9) |
| period | input | 8 | Top value for 8-bit width in period-top modes |
| cmp0 | input | 32 | Compare channel 0 |
| count | output | 32 | Counter value, masked to the width |
| wave | output | 1 | Waveform output |
| match_pulse | output | 1 | One-cycle compare match pulse |
| wrap_pulse | output | 1 | One-cycle wraparound pulse |

## Verification
The assertions watch four things on every cycle. The count holds between enabled ticks. An up-wrap lands on zero and a down-wrap lands on the top that was in force. A frequency-mode pin changes only after a match. A pulse-width wrap drives the pin to the level set by the direction. The bench scenarios cover the rest: how the top source depends jointly on width and mode, the reserved width code, masking when the width changes under a running count, and the priority of wrap over match when both land on the compare-channel top. The bench checks these against a reference model fed with seeded random configurations and a few directed sequences.

// File: rtl/wavetimer_pkg.sv
package wavetimer_pkg;

  typedef enum logic [1:0] {
    WID_16  = 2'd0,
    WID_8   = 2'd1,
    WID_32  = 2'd2,
    WID_RSV = 2'd3
  } width_e;

  typedef enum logic [1:0] {
    WV_FREQ_PER = 2'd0,
    WV_FREQ_CMP = 2'd1,
    WV_PWM_PER  = 2'd2,
    WV_PWM_CMP  = 2'd3
  } wave_e;

  function automatic logic mode_is_pwm(wave_e m);
    return (m == WV_PWM_PER) || (m == WV_PWM_CMP);
  endfunction

  function automatic logic mode_top_from_cmp(wave_e m);
    return (m == WV_FREQ_CMP) || (m == WV_PWM_CMP);
  endfunction

endpackage

// File: rtl/wt_limits.sv
module wt_limits
  import wavetimer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PER_W = 8
) (
  input  width_e             width_sel,
  input  wave_e              wave_mode,
  input  logic [PER_W-1:0]   period,
  input  logic [CNT_W-1:0]   cmp0,
  output logic [CNT_W-1:0]   mask,
  output logic [CNT_W-1:0]   top
);
  localparam int NARROW_W = 8;
  localparam int MID_W    = 16;
  localparam logic [CNT_W-1:0] ALL1   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MASK8  = ALL1 >> (CNT_W - NARROW_W);
  localparam logic [CNT_W-1:0] MASK16 = ALL1 >> (CNT_W - MID_W);

  function automatic logic [CNT_W-1:0] width_mask(width_e w);
    case (w)
      WID_8:   return MASK8;
      WID_32:  return ALL1;
      default: return MASK16;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] pick_top(wave_e m, width_e w,
                                                logic [CNT_W-1:0] per_ext,
                                                logic [CNT_W-1:0] cmp,
                                                logic [CNT_W-1:0] msk);
    if (mode_top_from_cmp(m)) return cmp & msk;
    else if (w == WID_8)      return per_ext & msk;
    else                      return msk;
  endfunction

  logic [CNT_W-1:0] per_ext;
  assign per_ext = CNT_W'(period);
  assign mask    = width_mask(width_sel);
  assign top     = pick_top(wave_mode, width_sel, per_ext, cmp0, mask);

  always_comb begin
    assert_top_in_width_R3: assert ((top & ~mask) == '0);
  end

endmodule

// File: rtl/wt_core.sv
module wt_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             down,
  input  logic [CNT_W-1:0] mask,
  input  logic [CNT_W-1:0] top,
  input  logic [CNT_W-1:0] cmp0,
  output logic [CNT_W-1:0] cnt_view,
  output logic             match_ev,
  output logic             wrap_ev,
  output logic             match_p,
  output logic             wrap_p
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  function automatic logic [CNT_W-1:0] next_count(logic [CNT_W-1:0] c,
                                                  logic dn, logic wrap,
                                                  logic [CNT_W-1:0] tp,
                                                  logic [CNT_W-1:0] msk);
    if (wrap) return dn ? tp : '0;
    else      return (dn ? (c - 1'b1) : (c + 1'b1)) & msk;
  endfunction

  assign cnt_view = cnt_q & mask;
  assign match_ev = step && (cnt_view == (cmp0 & mask));
  assign wrap_ev  = step && (down ? (cnt_view == '0) : (cnt_view >= top));
  assign cnt_nxt  = next_count(cnt_view, down, wrap_ev, top, mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      match_p <= 1'b0;
      wrap_p  <= 1'b0;
    end else begin
      if (step) cnt_q <= cnt_nxt;
      match_p <= match_ev;
      wrap_p  <= wrap_ev;
    end
  end

  assert_hold_without_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q));
  assert_pulse_after_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (match_p || wrap_p) |-> $past(step));
  assert_up_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_p && !$past(down)) |-> (cnt_q == '0));
  assert_down_wrap_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_p && $past(down)) |-> (cnt_q == $past(top)));

endmodule

// File: rtl/wt_wave.sv
module wt_wave
  import wavetimer_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  wave_e wave_mode,
  input  logic  down,
  input  logic  match_ev,
  input  logic  wrap_ev,
  output logic  wave_q
);
  logic pwm;
  logic wave_nxt;

  function automatic logic wave_next(logic cur, logic is_pwm, logic dn,
                                     logic mt, logic wr);
    if (is_pwm) begin
      if (wr)      return !dn;
      else if (mt) return dn;
      else         return cur;
    end else begin
      return mt ? !cur : cur;
    end
  endfunction

  assign pwm      = mode_is_pwm(wave_mode);
  assign wave_nxt = wave_next(wave_q, pwm, down, match_ev, wrap_ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_nxt;
  end

  assert_freq_change_on_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(pwm) && (wave_q != $past(wave_q))) |-> $past(match_ev));
  assert_pwm_wrap_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwm && wrap_ev) |-> (wave_q == !$past(down)));

endmodule

// File: rtl/wavetimer.sv
module wavetimer
  import wavetimer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic             count_down,
  input  logic [1:0]       width_sel,
  input  logic [1:0]       wave_mode,
  input  logic [PER_W-1:0] period,
  input  logic [CNT_W-1:0] cmp0,
  output logic [CNT_W-1:0] count,
  output logic             wave,
  output logic             match_pulse,
  output logic             wrap_pulse
);
  width_e           wsel;
  wave_e            wmode;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] top;
  logic             step;
  logic             match_ev;
  logic             wrap_ev;

  assign wsel  = width_e'(width_sel);
  assign wmode = wave_e'(wave_mode);
  assign step  = enable && tick;

  wt_limits #(.CNT_W(CNT_W), .PER_W(PER_W)) u_limits (
    .width_sel (wsel),
    .wave_mode (wmode),
    .period    (period),
    .cmp0      (cmp0),
    .mask      (mask),
    .top       (top)
  );

  wt_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .down     (count_down),
    .mask     (mask),
    .top      (top),
    .cmp0     (cmp0),
    .cnt_view (count),
    .match_ev (match_ev),
    .wrap_ev  (wrap_ev),
    .match_p  (match_pulse),
    .wrap_p   (wrap_pulse)
  );

  wt_wave u_wave (
    .clk       (clk),
    .rst_n     (rst_n),
    .wave_mode (wmode),
    .down      (count_down),
    .match_ev  (match_ev),
    .wrap_ev   (wrap_ev),
    .wave_q    (wave)
  );

endmodule

// File: tb/test_wavetimer.sv
module test_wavetimer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        tick = 1'b0;
  logic        count_down = 1'b0;
  logic [1:0]  width_sel = 2'd0;
  logic [1:0]  wave_mode = 2'd0;
  logic [7:0]  period = 8'd0;
  logic [31:0] cmp0 = 32'd0;
  logic [31:0] count;
  logic        wave;
  logic        match_pulse;
  logic        wrap_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [31:0] m_cnt  = 32'd0;
  logic        m_wave = 1'b0;

  always #4 clk = ~clk;

  wavetimer i_wavetimer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
    .count_down(count_down), .width_sel(width_sel), .wave_mode(wave_mode),
    .period(period), .cmp0(cmp0), .count(count), .wave(wave),
    .match_pulse(match_pulse), .wrap_pulse(wrap_pulse)
  );

  function automatic logic [31:0] ref_mask(logic [1:0] w);
    if (w == 2'd1)      return 32'h0000_00FF;
    else if (w == 2'd2) return 32'hFFFF_FFFF;
    else                return 32'h0000_FFFF;
  endfunction

  function automatic logic [31:0] ref_top(logic [1:0] m, logic [1:0] w,
                                          logic [7:0] p, logic [31:0] c);
    logic [31:0] mk;
    mk = ref_mask(w);
    if (m[0])         return c & mk;
    else if (w == 2'd1) return {24'd0, p};
    else              return mk;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cycle();
    logic [31:0] mk, tp, c, nxt;
    logic st, mev, wev, nw;
    mk  = ref_mask(width_sel);
    tp  = ref_top(wave_mode, width_sel, period, cmp0);
    c   = m_cnt & mk;
    st  = enable && tick;
    mev = st && (c == (cmp0 & mk));
    wev = st && (count_down ? (c == 32'd0) : (c >= tp));
    nxt = m_cnt;
    nw  = m_wave;
    if (st) begin
      if (count_down) nxt = wev ? tp : ((c - 32'd1) & mk);
      else            nxt = wev ? 32'd0 : ((c + 32'd1) & mk);
      if (wave_mode[1]) begin
        if (wev)      nw = !count_down;
        else if (mev) nw = count_down;
      end else if (mev) begin
        nw = !m_wave;
      end
    end
    @(posedge clk);
    #2;
    m_cnt  = nxt;
    m_wave = nw;
    chk("R2 R3 R6 count", count, nxt & mk);
    chk("R8 R9 wave", {31'd0, wave}, {31'd0, nw});
    chk("R7 match_pulse", {31'd0, match_pulse}, {31'd0, mev});
    chk("R6 wrap_pulse", {31'd0, wrap_pulse}, {31'd0, wev});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    enable = 1'b0;
    tick = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    chk("R1 count in reset", count, 32'd0);
    chk("R1 wave in reset", {31'd0, wave}, 32'd0);
    chk("R1 pulses in reset", {30'd0, match_pulse, wrap_pulse}, 32'd0);
    rst_n = 1'b1;
    m_cnt = 32'd0;
    m_wave = 1'b0;
    @(posedge clk);
    #2;
    chk("R1 count after reset", count, 32'd0);
    chk("R1 wave after reset", {31'd0, wave}, 32'd0);
  endtask

  task automatic setup(logic [1:0] m, logic [1:0] w, logic [7:0] p,
                       logic [31:0] c, logic dn);
    wave_mode = m; width_sel = w; period = p; cmp0 = c; count_down = dn;
    enable = 1'b1; tick = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // R3 R4: down from zero loads the width maximum (16, reserved=16, 32) or period (8)
    setup(2'd0, 2'd0, 8'h30, 32'd100, 1'b1); cycle();
    chk("R3 R4 16-bit down wrap top", count, 32'h0000_FFFF);
    do_reset();
    setup(2'd2, 2'd3, 8'h30, 32'd100, 1'b1); cycle();
    chk("R3 reserved width acts as 16-bit", count, 32'h0000_FFFF);
    do_reset();
    setup(2'd0, 2'd2, 8'h30, 32'd100, 1'b1); cycle();
    chk("R3 R4 32-bit down wrap top", count, 32'hFFFF_FFFF);
    do_reset();
    setup(2'd2, 2'd1, 8'h30, 32'd100, 1'b1); cycle();
    chk("R4 8-bit period top", count, 32'h0000_0030);
    chk("R6 down wrap pulse", {31'd0, wrap_pulse}, 32'd1);
    chk("R9 pwm down wrap clears", {31'd0, wave}, 32'd0);
    // R5 R3: compare top masked to 8 bits
    do_reset();
    setup(2'd1, 2'd1, 8'h30, 32'h1234_5678, 1'b1); cycle();
    chk("R5 R3 compare top masked", count, 32'h0000_0078);

    // R9: wrap and match coincide at compare top, wrap wins (set when up)
    do_reset();
    setup(2'd3, 2'd1, 8'h10, 32'd3, 1'b0);
    repeat (4) cycle();
    chk("R9 wrap beats match", {31'd0, wave}, 32'd1);
    chk("R7 match at top", {31'd0, match_pulse}, 32'd1);
    chk("R6 up wrap to zero", count, 32'd0);

    // R8: frequency toggles on every match
    do_reset();
    setup(2'd1, 2'd0, 8'h10, 32'd3, 1'b0);
    repeat (4) cycle();
    chk("R8 first toggle", {31'd0, wave}, 32'd1);
    repeat (4) cycle();
    chk("R8 second toggle", {31'd0, wave}, 32'd0);

    // R2: disabled ticks and enabled idle cycles do nothing
    enable = 1'b0; tick = 1'b1;
    repeat (3) cycle();
    chk("R2 disabled hold", count, 32'd0);
    enable = 1'b1; tick = 1'b0;
    repeat (3) cycle();
    chk("R2 no tick hold", count, 32'd0);
    chk("R2 no pulse without tick", {30'd0, match_pulse, wrap_pulse}, 32'd0);

    // Random phase: reconfigure every 64 cycles
    for (int blk = 0; blk < 60; blk++) begin
      wave_mode = 2'($urandom_range(0, 3));
      width_sel = 2'($urandom_range(0, 3));
      period    = 8'($urandom_range(0, 47));
      cmp0      = ($urandom_range(0, 7) == 0) ? $urandom : 32'($urandom_range(0, 47));
      for (int k = 0; k < 64; k++) begin
        enable = ($urandom_range(0, 15) != 0);
        tick   = ($urandom_range(0, 3) != 0);
        if ($urandom_range(0, 31) == 0) count_down = !count_down;
        cycle();
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule